// File: doc/BRIEF.md
# Manchester Bit-Sync Data Receiver

This block takes a one-bit data stream that an analog slicer has already turned into a clean logic level. It recovers the bit timing and turns the Manchester line code into NRZ bits. An internal prescaler derives a sample tick from the system clock, so that every bit cell holds a fixed number of samples. A digital phase-locked loop keeps a cell-phase counter. It nudges that counter by one sample whenever a line transition arrives near the expected mid-cell point. When a cell passes without any usable transition, the loop re-centres on the next transition it sees.

Each bit decision comes from an integrate-and-dump accumulator, not from a single sample. Samples in the first half-cell count positively and samples in the second half count negatively, each weighted by the line level. The sign of the total at the cell boundary gives the bit. The block emits the bit with a one-clock strobe. It also drives a lock flag that follows runs of well-placed mid-cell transitions. Word framing and error handling are left to the logic that consumes the strobe.

Top module: `msr_manchester_rx`

## Requirements
- R1: A sample tick occurs once every DIV = CLK_HZ/(BIT_RATE*OSR) clocks, and a bit cell spans OSR ticks. While the line has no transitions, nrz_valid recurs exactly every OSR*DIV clocks.
- R2: Line code: a 1 is sent high in the first half-cell and low in the second, and a 0 is sent the opposite way. Once locked, nrz_data at each strobe equals the bit whose mid-cell transition came most recently.
- R3: The integrator adds +1 per tick when the sample agrees with the half (high in the first half, low in the second) and -1 otherwise. At the cell boundary nrz_data is 1 only for a strictly positive total, and the total is then cleared. A line held constant therefore decodes as 0 in every cell.
- R4: nrz_valid is high for exactly one clock per recovered cell.
- R5: A transition within ±OSR/4 samples of mid-cell shifts the phase counter by one sample: forward when the transition is early, held back when it is late. Ticks without a transition advance the counter by exactly one. With cell lengths wandering by ±1 clock, lock stays high and the data stays correct.
- R6: locked rises at the strobe that completes LOCK_CELLS (8) consecutive cells, each containing a transition within ±LOCK_WIN (2) samples of mid-cell. It changes only at a strobe, and never rises before LOCK_CELLS strobes have followed the start of the data.
- R7: locked falls at the strobe of the LOCK_CELLS-th consecutive cell without such a transition.
- R8: If the previous cell had no transition inside the tracking window, the next transition outside it sets the phase so that this sample counts as mid-cell. A half-cell slip of the incoming stream is recovered, and correct locked data follows.
- R9: While rst_n is low, nrz_valid, nrz_data and locked are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_line | input | 1 | Sliced Manchester line level, asynchronous to clk |
| nrz_data | output | 1 | Decoded bit, valid while nrz_valid is high |
| nrz_valid | output | 1 | One-clock strobe per recovered bit cell |
| locked | output | 1 | Bit timing is locked |

## Verification
The bench holds the line constant to show that a tie in the integrator decodes as 0 and that the strobe free-runs at its nominal period. A design that sampled one point, or broke ties toward 1, would emit ones. It then sends data with random bits and random phase, then with cell lengths that wander by a clock. A loop that corrected in the wrong direction would lose lock and misdecode. A half-cell slip checks the re-centring path, since a loop without it stays parked on boundary transitions and decodes inverted bits. Finally the line goes silent and the bench counts strobes, so an off-by-one in the lock-loss run count shows up as a lock that drops one cell early or late.

// File: rtl/msr_pkg.sv
package msr_pkg;

  typedef enum logic [1:0] {
    PH_STEP = 2'd0,
    PH_ADV  = 2'd1,
    PH_HOLD = 2'd2,
    PH_JUMP = 2'd3
  } ph_act_e;

  // signed distance of a phase count from the mid-cell point
  function automatic int phase_err(int ph, int osr);
    return ph - (osr / 2);
  endfunction

  function automatic logic near_mid(int err, int win);
    return (err <= win) && (err >= -win);
  endfunction

  // integrator vote: sample agrees with the half it sits in
  function automatic logic half_agrees(logic sample, logic first_half);
    return sample == first_half;
  endfunction

endpackage

// File: rtl/msr_tick_gen.sv
module msr_tick_gen #(
  parameter int unsigned DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;

  assign tick = (cnt_q == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/msr_dpll.sv
module msr_dpll
  import msr_pkg::*;
#(
  parameter int unsigned OSR       = 16,
  parameter int unsigned TRACK_WIN = 4,
  parameter int unsigned LOCK_WIN  = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick,
  input  logic                   line_edge,
  output logic [$clog2(OSR)-1:0] phase,
  output logic                   first_half,
  output logic                   cell_end,
  output logic                   cell_hit,
  output ph_act_e                ph_act
);
  localparam int unsigned PW  = $clog2(OSR);
  localparam int unsigned MID = OSR / 2;

  logic [PW-1:0] phase_q, phase_nxt;
  logic          cur_track_q, prev_track_q, cur_lock_q;
  int            err;
  logic          in_track, in_lock;

  always_comb begin
    err      = phase_err(int'(phase_q), int'(OSR));
    in_track = line_edge && near_mid(err, int'(TRACK_WIN));
    in_lock  = line_edge && near_mid(err, int'(LOCK_WIN));
    if (in_track) begin
      if (err < 0)      ph_act = PH_ADV;
      else if (err > 0) ph_act = PH_HOLD;
      else              ph_act = PH_STEP;
    end else if (line_edge && !prev_track_q && !cur_track_q) begin
      ph_act = PH_JUMP;
    end else begin
      ph_act = PH_STEP;
    end
  end

  always_comb begin
    case (ph_act)
      PH_ADV:  phase_nxt = phase_q + PW'(2);
      PH_HOLD: phase_nxt = phase_q;
      PH_JUMP: phase_nxt = PW'(MID + 1);
      default: phase_nxt = (phase_q == PW'(OSR - 1)) ? '0 : phase_q + PW'(1);
    endcase
  end

  assign cell_end   = tick && (ph_act != PH_JUMP) && (phase_q == PW'(OSR - 1));
  assign cell_hit   = cur_lock_q;
  assign phase      = phase_q;
  assign first_half = (phase_q < PW'(MID));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q      <= '0;
      cur_track_q  <= 1'b0;
      prev_track_q <= 1'b0;
      cur_lock_q   <= 1'b0;
    end else if (tick) begin
      phase_q <= phase_nxt;
      if (cell_end) begin
        prev_track_q <= cur_track_q;
        cur_track_q  <= 1'b0;
        cur_lock_q   <= 1'b0;
      end else begin
        if (in_track || ph_act == PH_JUMP) cur_track_q <= 1'b1;
        if (in_lock)                       cur_lock_q  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/msr_lock_mon.sv
module msr_lock_mon #(
  parameter int unsigned LOCK_CELLS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cell_end,
  input  logic cell_hit,
  output logic locked
);
  localparam int unsigned CW = $clog2(LOCK_CELLS + 1);

  logic [CW-1:0] hit_run_q, miss_run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_run_q  <= '0;
      miss_run_q <= '0;
      locked     <= 1'b0;
    end else if (cell_end) begin
      if (cell_hit) begin
        miss_run_q <= '0;
        if (hit_run_q < CW'(LOCK_CELLS)) hit_run_q <= hit_run_q + CW'(1);
        if (hit_run_q == CW'(LOCK_CELLS - 1)) locked <= 1'b1;
      end else begin
        hit_run_q <= '0;
        if (miss_run_q < CW'(LOCK_CELLS)) miss_run_q <= miss_run_q + CW'(1);
        if (miss_run_q == CW'(LOCK_CELLS - 1)) locked <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/msr_integrator.sv
module msr_integrator
  import msr_pkg::*;
#(
  parameter int unsigned OSR = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic sample,
  input  logic first_half,
  input  logic cell_end,
  output logic nrz_data,
  output logic nrz_valid
);
  localparam int unsigned AW = $clog2(OSR) + 2;

  logic signed [AW-1:0] acc_q, acc_nxt;

  always_comb begin
    if (half_agrees(sample, first_half)) acc_nxt = acc_q + AW'(1);
    else                                 acc_nxt = acc_q - AW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q     <= '0;
      nrz_data  <= 1'b0;
      nrz_valid <= 1'b0;
    end else begin
      nrz_valid <= cell_end;
      if (cell_end) nrz_data <= (acc_nxt > 0);
      if (tick)     acc_q    <= cell_end ? '0 : acc_nxt;
    end
  end
endmodule

// File: rtl/msr_manchester_rx.sv
module msr_manchester_rx
  import msr_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 125_000_000,
  parameter int unsigned BIT_RATE    = 10_000,
  parameter int unsigned OSR         = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned TRACK_WIN   = OSR / 4,
  parameter int unsigned LOCK_WIN    = 2,
  parameter int unsigned LOCK_CELLS  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_line,
  output logic nrz_data,
  output logic nrz_valid,
  output logic locked
);
  localparam int unsigned RAW_DIV = CLK_HZ / (BIT_RATE * OSR);
  localparam int unsigned DIV     = (RAW_DIV < 1) ? 1 : RAW_DIV;
  localparam int unsigned PW      = $clog2(OSR);

  // event wires brought out for the checker
  logic          tick;
  logic          line_edge;
  logic          cell_end;
  logic          cell_hit;
  logic          first_half;
  logic [PW-1:0] phase;
  ph_act_e       ph_act;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   line_s;
  logic                   smp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], rx_line};
  end
  assign line_s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n)    smp_q <= 1'b0;
    else if (tick) smp_q <= line_s;
  end
  assign line_edge = tick && (line_s != smp_q);

  msr_tick_gen #(.DIV(DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick)
  );

  msr_dpll #(
    .OSR      (OSR),
    .TRACK_WIN(TRACK_WIN),
    .LOCK_WIN (LOCK_WIN)
  ) u_dpll (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .line_edge (line_edge),
    .phase     (phase),
    .first_half(first_half),
    .cell_end  (cell_end),
    .cell_hit  (cell_hit),
    .ph_act    (ph_act)
  );

  msr_integrator #(.OSR(OSR)) u_integ (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .sample    (line_s),
    .first_half(first_half),
    .cell_end  (cell_end),
    .nrz_data  (nrz_data),
    .nrz_valid (nrz_valid)
  );

  msr_lock_mon #(.LOCK_CELLS(LOCK_CELLS)) u_lock (
    .clk     (clk),
    .rst_n   (rst_n),
    .cell_end(cell_end),
    .cell_hit(cell_hit),
    .locked  (locked)
  );
endmodule

// File: rtl/msr_rx_checker.sv
module msr_rx_checker
  import msr_pkg::*;
#(
  parameter int unsigned OSR = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   tick,
  input logic                   line_edge,
  input logic                   cell_end,
  input logic [$clog2(OSR)-1:0] phase,
  input ph_act_e                ph_act,
  input logic                   nrz_valid,
  input logic                   locked
);
  localparam int unsigned PW = $clog2(OSR);

  assert_valid_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    nrz_valid |=> !nrz_valid);

  assert_valid_follows_cell_R1: assert property (@(posedge clk) disable iff (!rst_n)
    nrz_valid |-> $past(cell_end));

  assert_lock_moves_at_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (locked != $past(locked)) |-> nrz_valid);

  assert_free_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !line_edge) |=>
      phase == (($past(phase) == PW'(OSR - 1)) ? '0 : $past(phase) + PW'(1)));

  assert_correction_needs_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ph_act != PH_STEP) |-> line_edge);
endmodule

bind msr_manchester_rx msr_rx_checker #(.OSR(OSR)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (tick),
  .line_edge(line_edge),
  .cell_end (cell_end),
  .phase    (phase),
  .ph_act   (ph_act),
  .nrz_valid(nrz_valid),
  .locked   (locked)
);

// File: tb/tb_msr_manchester_rx.sv
module tb_msr_manchester_rx;
  localparam int OSR   = 16;
  localparam int DIVB  = 2;
  localparam int CELL  = OSR * DIVB;
  localparam int LOCKN = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_line = 1'b0;
  logic nrz_data, nrz_valid, locked;

  msr_manchester_rx #(
    .CLK_HZ  (OSR * DIVB * 10_000),
    .BIT_RATE(10_000),
    .OSR     (OSR)
  ) dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_line  (rx_line),
    .nrz_data (nrz_data),
    .nrz_valid(nrz_valid),
    .locked   (locked)
  );

  always #4 clk = ~clk;

  int    checks = 0, errors = 0, cyc = 0;
  int    last_strobe_cyc = -1, mid_cyc = 0, pre_strobes = 0;
  bit    last_mid_bit = 0, prev_valid = 0, lock_seen = 0;
  bit    chk_const = 0, chk_period = 0, chk_data = 0, chk_hold = 0, chk_rise = 0;
  string data_tag = "R2";

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit line_level(bit b, bit first);
    return first ? b : !b;
  endfunction

  task automatic send_bit(bit b, int len);
    rx_line = line_level(b, 1'b1);
    repeat (len / 2) @(negedge clk);
    rx_line = line_level(b, 1'b0);
    last_mid_bit = b;
    mid_cyc = cyc;
    repeat (len - len / 2) @(negedge clk);
  endtask

  task automatic wait_strobe();
    do @(negedge clk); while (!nrz_valid);
  endtask

  // output monitor, sampling at the falling edge
  always @(negedge clk) begin
    if (rst_n && nrz_valid) begin
      pre_strobes++;
      check(!prev_valid, "R4", 2, 1);
      if (chk_const) begin
        check(nrz_data == 1'b0, "R3", nrz_data, 0);
        if (chk_period && last_strobe_cyc >= 0)
          check(cyc - last_strobe_cyc == CELL, "R1", cyc - last_strobe_cyc, CELL);
      end
      if (chk_rise && locked && !lock_seen) begin
        lock_seen = 1;
        check(pre_strobes >= LOCKN, "R6", pre_strobes, LOCKN);
      end
      if (chk_data && locked)
        check(nrz_data == last_mid_bit, data_tag, nrz_data, last_mid_bit);
      if (chk_hold) check(locked, "R5", locked, 1);
      last_strobe_cyc = cyc;
    end
    prev_valid = nrz_valid;
  end

  initial begin
    repeat (150_000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 150_000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17));
    repeat (4) @(negedge clk);
    check(nrz_valid == 0, "R9", nrz_valid, 0);
    check(nrz_data == 0, "R9", nrz_data, 0);
    check(locked == 0, "R9", locked, 0);
    rst_n = 1'b1;

    // constant low: free-running strobe period, tie decodes as 0
    chk_const = 1; chk_period = 1;
    repeat (10 * CELL) @(negedge clk);
    chk_const = 0; chk_period = 0;
    // constant high after one edge (which re-centres)
    rx_line = 1'b1;
    repeat (2 * CELL) @(negedge clk);
    chk_const = 1;
    repeat (6 * CELL) @(negedge clk);
    chk_const = 0;
    check(locked == 0, "R7", locked, 0);

    // acquisition: preamble of alternating bits, then random data
    pre_strobes = 0; chk_rise = 1; chk_data = 1; data_tag = "R2";
    for (int i = 0; i < 8; i++) send_bit(bit'(i % 2 == 0), CELL);
    for (int i = 0; i < 16; i++) send_bit(bit'($urandom_range(1, 0)), CELL);
    check(locked == 1, "R6", locked, 1);
    chk_rise = 0;
    for (int i = 0; i < 24; i++) send_bit(bit'($urandom_range(1, 0)), CELL);

    // tracking: cell length wanders by one clock
    chk_hold = 1; data_tag = "R5";
    for (int i = 0; i < 60; i++)
      send_bit(bit'($urandom_range(1, 0)), CELL - 1 + int'($urandom_range(2, 0)));
    chk_hold = 0;

    // half-cell slip, then recovery
    chk_data = 0;
    repeat (CELL / 2) @(negedge clk);
    for (int i = 0; i < 24; i++) send_bit(bit'($urandom_range(1, 0)), CELL);
    chk_data = 1; data_tag = "R8";
    for (int i = 0; i < 30; i++) send_bit(bit'($urandom_range(1, 0)), CELL);
    check(locked == 1, "R8", locked, 1);
    chk_data = 0;

    // silence: lock falls on the 8th missed cell
    if (last_strobe_cyc <= mid_cyc) wait_strobe();
    check(locked == 1, "R7", locked, 1);
    for (int k = 1; k <= LOCKN; k++) begin
      wait_strobe();
      check(locked == (k < LOCKN), "R7", locked, int'(k < LOCKN));
    end

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule